// File: doc/BRIEF.md
# Oversampled Serial Receiver with Frame Acceptance Filter

This block is the receive half of a small controller's serial port. It watches a single serial input line, which it samples on a tick that runs at sixteen times the bit rate. After a falling edge it times each bit and decides the bit's value by majority over three samples taken mid-bit. A start bit that does not hold low is treated as noise. Each completed frame is either stored or dropped. The decision depends on whether the previous frame is still unread and on an optional address filter.

Software sees one 8-bit control/status register and one receive buffer. The control register selects the frame format, enables reception and turns on the filter. It also holds the unread flag and the extra received bit. Bit 7 of the register has two roles, chosen by a side input. With the input low, bit 7 is the upper mode bit. With it high, bit 7 is a sticky flag that records a stop bit received as 0.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the control register reads 0x00, the receive buffer reads 0x00 and `rx_irq` is low.
- R2: In mode 01 (control bits 7:6) a frame is start, eight data bits sent least significant bit first, then stop. An accepted frame puts the data in the buffer and the stop bit in control bit 2, and sets the unread flag in control bit 0, which drives `rx_irq`.
- R3: In modes 10 and 11 a ninth bit follows the eight data bits, ahead of the stop bit. On acceptance, the ninth bit goes into control bit 2.
- R4: Each bit is sampled on the 7th, 8th and 9th ticks after the bit's start, counted from the detected falling edge. The bit takes the value seen in at least two of the three samples, so one wrong sample at the 8th tick has no effect.
- R5: If the voted start bit is 1, the receiver returns to idle without storing anything. The next falling edge begins a new frame, which is received correctly.
- R6: While the unread flag is 1, a completed frame is discarded. The buffer, control bit 2 and the flag all keep their values.
- R7: With the filter enable (control bit 5) set, a frame is stored only if its filter bit is 1. The filter bit is the stop bit in mode 01 and the ninth bit in modes 10 and 11. Other frames are discarded.
- R8: A completed frame with a stop bit of 0 sets the error flag, even if the frame is discarded. When `alt_view` is 1, control bit 7 reads and writes the error flag. When `alt_view` is 0, bit 7 reads and writes the upper mode bit, and the error flag is left unchanged.
- R9: Reception requires the enable bit (control bit 4). Edges are ignored while it is 0, and clearing it part-way through a frame abandons that frame.
- R10: Mode 00 never starts a reception.
- R11: The unread flag rises at the 9th tick of the stop bit, before the stop bit ends. After that it falls only when software writes 0 to control bit 0.

Control bits 3 and 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16x bit rate |
| rxd | input | 1 | Serial line, idles high |
| reg_we | input | 1 | Write strobe for control register |
| reg_wdata | input | 8 | Control register write data |
| alt_view | input | 1 | Selects error flag instead of upper mode bit at bit 7 |
| ctl_rdata | output | 8 | Control register read value |
| rbuf_rdata | output | 8 | Receive buffer |
| rx_irq | output | 1 | Unread flag |

## Verification
The most telling faults here are a sample phase that has drifted or a bit counter that is off by one. A drift shows up as a buffer byte that is shifted, or that mixes in the stop level. An off-by-one count moves the rise of `rx_irq` to another tick, so the bench pins that rise to the 9th tick of the stop bit. A wrong acceptance gate becomes visible one frame later: a frame that should have been dropped overwrites the buffer, or `rx_irq` rises with no entry expected. Mishandling of the shared bit 7 appears in the very next read of the control register.

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  input  logic       alt_view,
  output logic [7:0] ctl_rdata,
  output logic [7:0] rbuf_rdata,
  output logic       rx_irq
);
  localparam int PW  = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam logic [PW-1:0] PH_A   = PW'(MID - 2);
  localparam logic [PW-1:0] PH_B   = PW'(MID - 1);
  localparam logic [PW-1:0] PH_C   = PW'(MID);
  localparam logic [PW-1:0] PH_END = PW'(OVS - 1);

  logic sync1, sync2, rx_prev;
  logic m_hi, m_lo, filt, en, rb8, ri, fe;
  logic [7:0] rbuf, shreg;
  logic busy, ninth;
  logic [PW-1:0] phase;
  logic [3:0] bidx;
  logic [1:0] smp;

  wire unused_wbits = ^{reg_wdata[3], reg_wdata[1]};

  wire en_nxt    = reg_we ? reg_wdata[4] : en;
  wire mode_ok   = m_hi | m_lo;
  wire fall      = rx_prev & ~sync2;
  wire vote      = (smp[0] & smp[1]) | (smp[0] & sync2) | (smp[1] & sync2);
  wire decide    = busy & os_tick & (phase == PH_C);
  wire last      = bidx == (m_hi ? 4'd10 : 4'd9);
  wire flt_bit   = m_hi ? ninth : vote;
  wire frame_end = decide & last;
  wire accept    = frame_end & ~ri & (~filt | flt_bit);

  assign ctl_rdata  = {alt_view ? fe : m_hi, m_lo, filt, en, 1'b0, rb8, 1'b0, ri};
  assign rbuf_rdata = rbuf;
  assign rx_irq     = ri;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi <= 1'b0; m_lo <= 1'b0; filt <= 1'b0; en <= 1'b0;
      rb8 <= 1'b0; ri <= 1'b0; fe <= 1'b0; rbuf <= '0;
    end else begin
      if (reg_we) begin
        if (alt_view) fe <= reg_wdata[7];
        else          m_hi <= reg_wdata[7];
        m_lo <= reg_wdata[6];
        filt <= reg_wdata[5];
        en   <= reg_wdata[4];
        rb8  <= reg_wdata[2];
        ri   <= reg_wdata[0];
      end
      if (accept) begin
        rbuf <= shreg;
        rb8  <= m_hi ? ninth : vote;
        ri   <= 1'b1;
      end
      if (frame_end && !vote) fe <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1; sync2 <= 1'b1; rx_prev <= 1'b1;
      busy <= 1'b0; phase <= '0; bidx <= '0; smp <= '0;
      shreg <= '0; ninth <= 1'b0;
    end else begin
      sync1   <= rxd;
      sync2   <= sync1;
      rx_prev <= sync2;
      if (!en_nxt) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (fall && mode_ok) begin
          busy  <= 1'b1;
          phase <= '0;
          bidx  <= '0;
        end
      end else if (os_tick) begin
        phase <= (phase == PH_END) ? '0 : phase + 1'b1;
        if (phase == PH_A) smp[0] <= sync2;
        if (phase == PH_B) smp[1] <= sync2;
        if (phase == PH_C) begin
          if (bidx == 4'd0) begin
            if (vote) busy <= 1'b0;
          end else if (bidx <= 4'd8) begin
            shreg <= {vote, shreg[7:1]};
          end else if (!last) begin
            ninth <= vote;
          end
          if (last) busy <= 1'b0;
        end
        if (phase == PH_END) bidx <= bidx + 1'b1;
      end
    end
  end

  assert_ri_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ri && !(reg_we && !reg_wdata[0]) |=> ri);
  assert_buf_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ri |=> $stable(rbuf_rdata));
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !reg_we |=> !busy);
  assert_ri_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) |-> ($past(reg_we) || $past(busy)));
  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bidx <= 4'd10);
  assert_fe_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe) |-> ($past(reg_we) || $past(busy)));
endmodule

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1, reg_we = 1'b0, alt_view = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ctl_rdata, rbuf_rdata;
  logic rx_irq;
  int n_cmp = 0, n_bad = 0;
  logic [8:0] expq[$];
  logic [7:0] cur_ctl = '0;
  logic irq_q = 1'b0;

  always #5 clk = ~clk;

  serial_rx_core u_serial_rx_core (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cur_ctl = d;
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic slot(input logic v);
    rxd = v; os_tick = 1'b0;
    repeat (3) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  endtask

  task automatic send_frame(input bit nine, input logic [7:0] d, input logic b9,
                            input logic sv, input int gl, input int abort_at, input bit exp_ok);
    int nb;
    logic v;
    nb = nine ? 11 : 10;
    if (exp_ok) expq.push_back({nine ? b9 : sv, d});
    for (int b = 0; b < nb; b++) begin
      if (b == 0) v = 1'b0;
      else if (b <= 8) v = d[b-1];
      else if (b == nb - 1) v = sv;
      else v = b9;
      if (b == abort_at) wr(cur_ctl & 8'hEF);
      for (int s = 1; s <= 16; s++) begin
        if (b == nb - 1 && s == 9 && exp_ok && abort_at < 0)
          chk(rx_irq == 1'b0, "R11 flag low before 9th stop tick", rx_irq, 0);
        slot((s == 8 && b == gl) ? ~v : v);
        if (b == nb - 1 && s == 9 && exp_ok && abort_at < 0)
          chk(rx_irq == 1'b1, "R11 flag high at 9th stop tick", rx_irq, 1);
      end
    end
    slot(1'b1); slot(1'b1);
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_irq && !irq_q) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R6/R7 unexpected frame stored", rbuf_rdata, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({ctl_rdata[2], rbuf_rdata} == e, "R2/R3 stored frame", {ctl_rdata[2], rbuf_rdata}, e);
      end
    end
    irq_q = rx_irq;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_rdata == 8'h00, "R1 control reset", ctl_rdata, 0);
    chk(rbuf_rdata == 8'h00, "R1 buffer reset", rbuf_rdata, 0);
    chk(rx_irq == 1'b0, "R1 irq reset", rx_irq, 0);
    slot(1'b1); slot(1'b1);

    wr(8'h50);
    send_frame(0, 8'hA5, 0, 1, -1, -1, 1);
    wr(8'h50);
    send_frame(0, 8'h3C, 0, 1, 3, -1, 1);   // R4 glitch in a data bit
    wr(8'h50);
    send_frame(0, 8'h96, 0, 1, 0, -1, 1);   // R4 glitch in start bit
    wr(8'h50);

    wr(8'h90);
    send_frame(1, 8'h5A, 0, 1, -1, -1, 1);  // R3 ninth 0
    wr(8'hD0);
    send_frame(1, 8'hC3, 1, 1, -1, -1, 1);  // R3 ninth 1
    wr(8'h50);

    // R5 false start: low for ticks 1..7 only
    for (int s = 1; s <= 16; s++) slot(s <= 7 ? 1'b0 : 1'b1);
    slot(1'b1);
    chk(rx_irq == 1'b0, "R5 false start stored nothing", rx_irq, 0);
    send_frame(0, 8'h81, 0, 1, -1, -1, 1);
    wr(8'h50);

    // R6 unread flag blocks next frame
    send_frame(0, 8'h11, 0, 1, -1, -1, 1);
    send_frame(0, 8'h22, 0, 1, -1, -1, 0);
    chk(rbuf_rdata == 8'h11, "R6 buffer kept", rbuf_rdata, 8'h11);
    chk(rx_irq == 1'b1, "R6 flag kept", rx_irq, 1);
    wr(8'h50);

    // R7 filter in 9-bit mode
    wr(8'hF0);
    send_frame(1, 8'h44, 0, 1, -1, -1, 0);
    chk(rx_irq == 1'b0 && rbuf_rdata == 8'h22 - 8'h11, "R7 ninth 0 dropped", rbuf_rdata, 8'h11);
    send_frame(1, 8'h45, 1, 1, -1, -1, 1);
    wr(8'h70);
    // R7 filter in 8-bit mode, stop 0 dropped (also sets error flag)
    send_frame(0, 8'h66, 0, 0, -1, -1, 0);
    chk(rx_irq == 1'b0 && rbuf_rdata == 8'h45, "R7 stop 0 dropped", rbuf_rdata, 8'h45);

    // R8 shared bit 7
    alt_view = 1'b1;
    @(negedge clk);
    chk(ctl_rdata[7] == 1'b1, "R8 error flag from dropped frame", ctl_rdata[7], 1);
    wr(8'h50);
    chk(ctl_rdata[7] == 1'b0, "R8 error flag cleared", ctl_rdata[7], 0);
    send_frame(0, 8'h7E, 0, 0, -1, -1, 1);
    chk(ctl_rdata[7] == 1'b1, "R8 error flag on stop 0", ctl_rdata[7], 1);
    alt_view = 1'b0;
    @(negedge clk);
    chk(ctl_rdata[7] == 1'b0, "R8 bit 7 shows mode", ctl_rdata[7], 0);
    alt_view = 1'b1;
    wr(8'hD0);
    alt_view = 1'b0;
    @(negedge clk);
    chk(ctl_rdata[7:6] == 2'b01, "R8 write went to error flag not mode", ctl_rdata[7:6], 1);
    alt_view = 1'b1;
    wr(8'h50);
    chk(ctl_rdata[7] == 1'b0, "R8 error flag written 0", ctl_rdata[7], 0);
    alt_view = 1'b0;

    // R9 enable
    wr(8'h40);
    send_frame(0, 8'h33, 0, 1, -1, -1, 0);
    chk(rx_irq == 1'b0, "R9 disabled ignores frame", rx_irq, 0);
    wr(8'h50);
    send_frame(0, 8'h34, 0, 1, -1, 3, 0);
    chk(rx_irq == 1'b0, "R9 abort mid-frame", rx_irq, 0);
    wr(8'h50);
    send_frame(0, 8'h35, 0, 1, -1, -1, 1);
    wr(8'h50);

    // R10 mode 00
    wr(8'h10);
    send_frame(0, 8'h99, 0, 1, -1, -1, 0);
    chk(rx_irq == 1'b0, "R10 mode 00 ignores frame", rx_irq, 0);

    chk(expq.size() == 0, "R2 all expected frames seen", expq.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule